// File: doc/BRIEF.md
# Frame-Clocked Serial Register Interface

This block is the slave side of a control port through which a host processor reaches eight 8-bit control registers over a single bidirectional data pin. There is no dedicated serial clock: the port steps one bit per rising edge of the 8 kHz frame sync. An active-low enable frames each transaction. A transaction is eleven bit slots long: a 3-bit register address, most significant bit first, and then eight data bits, also MSB first. The frame sync, the enable and the data pin are brought into the block's clock domain through a shared synchronizer before they are used.

A read takes two transactions. The host first writes a command into the highest register. That command holds a read flag and the address of the register to be read. On the next transaction the block takes over the data pin and shifts the selected register out. It hands the pin back to the host once the enable goes high. The register contents are driven out in parallel so that the surrounding logic can decode them.

Top module: `fsync_reg_port`

## Requirements
- R1: After reset all eight registers read 0x00 on `regs_o` and the data pin is an input (`sdata_oe_o` = 0).
- R2: A transaction starts only at a frame-sync rising edge at which the enable is low. That edge samples the first slot, and each later frame-sync rising edge samples exactly one more slot. Clock cycles without a frame-sync edge move nothing.
- R3: A write transaction carries the slots in the order A2, A1, A0, D7 … D0. Register A[2:0] takes D[7:0], and it does so only when the D0 slot is sampled, not before.
- R4: If the enable goes high before the D0 slot has been sampled, the transaction ends and no register changes.
- R5: Register 7 is the read command. Bit 3 is the read flag and bits 2:0 are the address to read. A written read flag is stored only when bits 2:0 name registers 0–6. When bits 2:0 are 7, bit 3 is stored as 0 and no read is armed.
- R6: When the read flag is set at the start edge of a transaction, the block drives the pin (`sdata_oe_o` = 1) from that edge onward. It drives 0 in the A1 and A0 slots and then bits 7 down to 0 of the addressed register in the eight data slots. Each slot's value appears after the edge before the one that samples it. In a transaction started without the flag, `sdata_oe_o` stays 0.
- R7: The read flag clears at the start edge of the read transaction, even if that transaction is cut short. The bits the host sends during a read transaction change no register.
- R8: `sdata_oe_o` returns to 0 within the synchronizer delay of the enable going high.
- R9: A write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync; its rising edges pace the bit slots |
| sden_n_i | input | 1 | Active-low transaction enable from the host |
| sdata_i | input | 1 | Data pin value as seen at the pad |
| sdata_o | output | 1 | Value driven onto the data pin during a read |
| sdata_oe_o | output | 1 | Pad output enable for the data pin |
| regs_o | output | 64 | Register contents, register i in bits [8i+7:8i] |

## Verification
The bench holds the enable low across many clock cycles with no frame-sync edge before a write. A design that shifts on the system clock would then load junk. It checks a register just before and just after the D0 edge, which catches a write that lands one slot early. It cuts writes short at five and at ten bits, so that a write committed on a partial count would show up on `regs_o`. The read tests send all-ones and alternating patterns during the read slots, so a design that also wrote during a read would corrupt register 7 or another register. Two more cases are a command that names register 7 and a read that is aborted after five slots. A design that armed a read it should refuse, or that kept the flag after the aborted read, would drive the pin on the next write.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_HOLD  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-2:0] level_o,
    output logic         rise0_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic                     last0;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.pipe[i] = sync_q.pipe[i-1];
        end
        sync_d.last0 = sync_q.pipe[STAGES-1][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.pipe  <= {STAGES{RST_VAL}};
            sync_q.last0 <= RST_VAL[0];
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q.pipe[STAGES-1][W-1:1];
    assign rise0_o = sync_q.pipe[STAGES-1][0] & ~sync_q.last0;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise0_o |=> !rise0_o); // R2

endmodule

// File: rtl/fsr_seq.sv
module fsr_seq
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_rise,
    input  logic              sden_n,
    input  logic              sdin,
    input  logic              read_armed,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              clr_read,
    output logic              dout,
    output logic              oe
);

    localparam int TOTAL = ADDR_W + DATA_W;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] CNT_DATA0 = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(TOTAL);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [TOTAL-2:0]  shin;
        logic              rd;
        logic [DATA_W-1:0] tx;
        logic              dout;
        logic              oe;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [TOTAL-1:0] shin_nx;
    logic [CNT_W-1:0] cnt_nx;

    assign shin_nx = {seq_q.shin, sdin};
    assign cnt_nx  = seq_q.cnt + 1'b1;
    assign wr_addr = shin_nx[TOTAL-1 -: ADDR_W];
    assign wr_data = shin_nx[DATA_W-1:0];

    always_comb begin
        seq_d    = seq_q;
        wr_en    = 1'b0;
        clr_read = 1'b0;
        if (sden_n) begin
            seq_d.state = SEQ_IDLE;
            seq_d.cnt   = '0;
            seq_d.rd    = 1'b0;
            seq_d.oe    = 1'b0;
            seq_d.dout  = 1'b0;
        end else if (fs_rise) begin
            case (seq_q.state)
                SEQ_IDLE: begin
                    seq_d.state = SEQ_SHIFT;
                    seq_d.cnt   = CNT_ONE;
                    seq_d.shin  = shin_nx[TOTAL-2:0];
                    seq_d.rd    = read_armed;
                    seq_d.oe    = read_armed;
                    seq_d.tx    = rd_data;
                    seq_d.dout  = 1'b0;
                    clr_read    = read_armed;
                end
                SEQ_SHIFT: begin
                    seq_d.shin = shin_nx[TOTAL-2:0];
                    seq_d.cnt  = cnt_nx;
                    if (seq_q.cnt == CNT_LAST) begin
                        seq_d.state = SEQ_HOLD;
                        seq_d.dout  = 1'b0;
                        wr_en       = ~seq_q.rd;
                    end else if (seq_q.rd && (cnt_nx >= CNT_DATA0)) begin
                        seq_d.dout = seq_q.tx[DATA_W-1];
                        seq_d.tx   = {seq_q.tx[DATA_W-2:0], 1'b0};
                    end else begin
                        seq_d.dout = 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dout = seq_q.dout;
    assign oe   = seq_q.oe;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt <= CNT_MAX); // R2
    AST_OE_DROPS_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sden_n |=> !seq_q.oe); // R8
    AST_OE_STARTS_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.oe) |-> $past(fs_rise)); // R6
    AST_PIN_QUIET_AS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.oe |-> !seq_q.dout); // R6

endmodule

// File: rtl/fsr_regfile.sv
module fsr_regfile #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               waddr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic                            clr_read,
    output logic [(1<<ADDR_W)*DATA_W-1:0]   regs_o,
    output logic                            read_armed,
    output logic [DATA_W-1:0]               rd_data
);

    localparam int NREG    = 1 << ADDR_W;
    localparam int CMD_IDX = NREG - 1;
    localparam int RFLAG   = ADDR_W;
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NREG - 1);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we) begin
            rf_d.regs[waddr] = wdata;
            if ((waddr == CMD_ADDR) && (wdata[ADDR_W-1:0] == CMD_ADDR)) begin
                rf_d.regs[CMD_IDX][RFLAG] = 1'b0;
            end
        end
        if (clr_read) begin
            rf_d.regs[CMD_IDX][RFLAG] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign regs_o     = rf_q.regs;
    assign read_armed = rf_q.regs[CMD_IDX][RFLAG];
    assign rd_data    = rf_q.regs[rf_q.regs[CMD_IDX][ADDR_W-1:0]];

    AST_FLAG_NEVER_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q.regs[CMD_IDX][RFLAG] |-> (rf_q.regs[CMD_IDX][ADDR_W-1:0] != CMD_ADDR)); // R5

    for (genvar gi = 0; gi < NREG; gi++) begin : g_hold_chk
        AST_UNTOUCHED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!(we && (waddr == ADDR_W'(gi))) && !(clr_read && (gi == CMD_IDX)))
            |=> $stable(rf_q.regs[gi])); // R9
    end

endmodule

// File: rtl/fsync_reg_port.sv
module fsync_reg_port #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fsync_i,
    input  logic                          sden_n_i,
    input  logic                          sdata_i,
    output logic                          sdata_o,
    output logic                          sdata_oe_o,
    output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o
);

    logic [1:0]        lvl_w;
    logic              fs_rise_w;
    logic              wr_en_w;
    logic [ADDR_W-1:0] wr_addr_w;
    logic [DATA_W-1:0] wr_data_w;
    logic              clr_read_w;
    logic              read_armed_w;
    logic [DATA_W-1:0] rd_data_w;

    fsr_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdata_i, sden_n_i, fsync_i}),
        .level_o (lvl_w),
        .rise0_o (fs_rise_w)
    );

    fsr_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs_rise    (fs_rise_w),
        .sden_n     (lvl_w[0]),
        .sdin       (lvl_w[1]),
        .read_armed (read_armed_w),
        .rd_data    (rd_data_w),
        .wr_en      (wr_en_w),
        .wr_addr    (wr_addr_w),
        .wr_data    (wr_data_w),
        .clr_read   (clr_read_w),
        .dout       (sdata_o),
        .oe         (sdata_oe_o)
    );

    fsr_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (wr_en_w),
        .waddr      (wr_addr_w),
        .wdata      (wr_data_w),
        .clr_read   (clr_read_w),
        .regs_o     (regs_o),
        .read_armed (read_armed_w),
        .rd_data    (rd_data_w)
    );

    AST_FLAG_GONE_ON_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe_o) |-> !read_armed_w); // R7
    AST_NO_WRITE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe_o |-> !wr_en_w); // R7

endmodule

// File: tb/sim_fsync_reg_port.sv
module sim_fsync_reg_port;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        sden_n = 1'b1;
    logic        sdata = 1'b0;
    logic        sdata_o;
    logic        sdata_oe_o;
    logic [63:0] regs_o;

    int total = 0;
    int fails = 0;
    logic [7:0] model [8];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    event       got_ev;

    always #4 clk = ~clk;

    fsync_reg_port u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync_i    (fsync),
        .sden_n_i   (sden_n),
        .sdata_i    (sdata),
        .sdata_o    (sdata_o),
        .sdata_oe_o (sdata_oe_o),
        .regs_o     (regs_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 8; i++) chk(req, {56'd0, regs_o[i*8 +: 8]}, {56'd0, model[i]});
    endtask

    task automatic frame(input logic en_n, input logic b, output logic so, output logic soe);
        @(negedge clk);
        sden_n = en_n;
        sdata  = b;
        repeat (HALF) @(negedge clk);
        so    = sdata_o;
        soe   = sdata_oe_o;
        fsync = 1'b1;
        repeat (HALF) @(negedge clk);
        fsync = 1'b0;
    endtask

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        model[a] = d;
        if (a == 3'd7 && d[2:0] == 3'd7) model[7][3] = 1'b0;
    endtask

    task automatic write_txn(input logic [2:0] a, input logic [7:0] d);
        logic [10:0] bits;
        logic so, soe, any_oe;
        bits = {a, d};
        any_oe = 1'b0;
        for (int j = 0; j < 11; j++) begin
            frame(1'b0, bits[10-j], so, soe);
            any_oe |= soe;
        end
        frame(1'b1, 1'b0, so, soe);
        any_oe |= soe;
        chk("R6 pin stays input during write", {63'd0, any_oe}, 64'd0);
        model_write(a, d);
    endtask

    task automatic partial_txn(input logic [2:0] a, input logic [7:0] d, input int nbits);
        logic [10:0] bits;
        logic so, soe;
        bits = {a, d};
        for (int j = 0; j < nbits; j++) frame(1'b0, bits[10-j], so, soe);
        frame(1'b1, 1'b0, so, soe);
    endtask

    task automatic read_txn(input logic [10:0] junk);
        logic [7:0] got;
        logic so, soe;
        logic oe_bad, addr_bad;
        exp_q.push_back(model[model[7][2:0]]);
        model[7][3] = 1'b0;
        got = '0;
        oe_bad = 1'b0;
        addr_bad = 1'b0;
        for (int j = 0; j < 11; j++) begin
            frame(1'b0, junk[10-j], so, soe);
            if (j == 0) begin
                if (soe !== 1'b0) oe_bad = 1'b1;
            end else begin
                if (soe !== 1'b1) oe_bad = 1'b1;
            end
            if (j == 1 || j == 2) begin
                if (so !== 1'b0) addr_bad = 1'b1;
            end
            if (j >= 3) got[10-j] = so;
        end
        chk("R6 pin driven from start edge", {63'd0, oe_bad}, 64'd0);
        chk("R6 address slots driven low", {63'd0, addr_bad}, 64'd0);
        frame(1'b1, 1'b0, so, soe);
        chk("R8 pin returns to input", {63'd0, sdata_oe_o}, 64'd0);
        got_q.push_back(got);
        ->got_ev;
    endtask

    // scoreboard monitor: compares each read-back byte with the expected one
    initial begin
        forever begin
            @(got_ev);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] g, e;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                chk("R6 read data", {56'd0, g}, {56'd0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic so, soe;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        check_regs("R1 reset value");
        chk("R1 pin is input", {63'd0, sdata_oe_o}, 64'd0);

        // R2 enable held low with no frame edges must shift nothing
        @(negedge clk);
        sden_n = 1'b0;
        sdata  = 1'b1;
        repeat (40) @(negedge clk);
        write_txn(3'd0, 8'hA5);
        check_regs("R2 R3 write after long idle low");

        // R3 R9 several registers
        write_txn(3'd1, 8'h3C);
        write_txn(3'd2, 8'h81);
        write_txn(3'd3, 8'h7E);
        write_txn(3'd5, 8'hFF);
        write_txn(3'd6, 8'h5A);
        check_regs("R9 only addressed registers change");

        // R3 write lands exactly at the D0 sample
        begin
            logic [10:0] bits;
            bits = {3'd4, 8'hC3};
            for (int j = 0; j < 10; j++) frame(1'b0, bits[10-j], so, soe);
            chk("R3 no change before D0", {56'd0, regs_o[32 +: 8]}, {56'd0, model[4]});
            frame(1'b0, bits[0], so, soe);
            chk("R3 change at D0", {56'd0, regs_o[32 +: 8]}, 64'hC3);
            frame(1'b1, 1'b0, so, soe);
            model[4] = 8'hC3;
        end

        // R4 early deassert discards
        partial_txn(3'd2, 8'h00, 5);
        partial_txn(3'd6, 8'h00, 10);
        check_regs("R4 partial write discarded");

        // R5 read command naming register 7 is refused
        write_txn(3'd7, 8'h0F);
        chk("R5 flag not stored for address 7", {56'd0, regs_o[56 +: 8]}, 64'h07);
        write_txn(3'd1, 8'h99);
        check_regs("R5 following write unaffected");

        // R5 R6 R7 arm and read register 3 with all-ones junk
        write_txn(3'd7, 8'h0B);
        chk("R5 flag stored", {56'd0, regs_o[56 +: 8]}, 64'h0B);
        read_txn(11'h7FF);
        check_regs("R7 flag cleared and junk not written");

        // further reads with alternating junk
        write_txn(3'd7, 8'h08);
        read_txn(11'h555);
        write_txn(3'd7, 8'h0E);
        read_txn(11'h2AA);
        check_regs("R7 registers after reads");

        // R7 R8 aborted read still consumes the flag
        write_txn(3'd7, 8'h0D);
        model[7][3] = 1'b0;
        for (int j = 0; j < 5; j++) frame(1'b0, 1'b1, so, soe);
        chk("R6 pin driven in aborted read", {63'd0, soe}, 64'd1);
        frame(1'b1, 1'b0, so, soe);
        chk("R8 pin released after abort", {63'd0, sdata_oe_o}, 64'd0);
        check_regs("R7 flag cleared by aborted read");
        write_txn(3'd2, 8'h24);
        check_regs("R7 next transaction is a plain write");

        repeat (5) @(negedge clk);
        chk("R6 scoreboard drained", {32'd0, 32'(got_q.size() + exp_q.size())}, 64'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule